// File: doc/BRIEF.md
# Serial Flash Sector Lock Unit

This block holds the volatile protection state of a serial NOR flash: two lock bits for every sector, a write-lock bit that blocks program and erase, and a lock-down bit that freezes both bits of its sector until the next reset. Commands arrive on a single-bit SPI slave link (mode 0). The link pins are brought into the system clock domain through a synchronizer. All decoding, shifting and register updates run on the system clock. The serial clock must therefore be several times slower than `clk`.

Two commands are decoded. The read command returns a sector's lock byte and repeats it for as long as chip select stays low. The write command changes the two lock bits of a sector. It needs the write enable latch, which is an input here. When the write executes, the block raises a one-cycle clear pulse for that latch. A busy input marks a program, erase or write cycle in progress, and any command that starts during such a cycle is refused. A combinational query port tells the array controller whether program or erase is allowed on a given sector.

The control state machine has these states:
- `S_IDLE`: chip select is high.
- `S_OPCODE`: eight command bits are shifted in.
- `S_ADDR`: twenty-four address bits are shifted in.
- `S_WDATA`: write data is shifted in.
- `S_RDATA`: the lock byte is shifted out.
- `S_IGNORE`: the frame is dropped until chip select rises.

Its transitions are:
- Any state moves to `S_IDLE` when chip select is high.
- `S_IDLE` moves to `S_OPCODE` when chip select falls.
- `S_OPCODE` moves to `S_ADDR` on the eighth bit when the command is accepted. Otherwise it moves to `S_IGNORE`.
- `S_ADDR` moves to `S_RDATA` or to `S_WDATA` on the twenty-fourth bit, depending on the command.

Top module: `sector_lock_unit`

## Requirements
- R1: After reset, every sector's lock bits are 0, `qry_pe_ok` is 1 for every sector, `spi_miso` is 0 and `wel_clr` is 0.
- R2: Read frame: opcode 0xE8 is sent MSB first, then a 24-bit address whose bits 23:16 select the sector. The block then shifts out the lock byte MSB first, changing `spi_miso` after each falling SCK edge. The byte is {bits 7:2 = 0, bit 1 = lock-down, bit 0 = write-lock}.
- R3: While chip select stays low after a read address, the same lock byte is repeated byte after byte.
- R4: If `busy` is high when the eighth opcode bit is taken, the command is refused: `spi_miso` stays 0 for the whole frame and no state changes.
- R5: Write frame: opcode 0xE5, then a 24-bit address, then data bytes. The write needs `wel` high and `busy` low at the end of the opcode. When chip select rises after a whole number (at least one) of data bytes, bits 1:0 of the last byte are stored as lock-down and write-lock. Data bits 7:2 are dropped.
- R6: A write frame sent with `wel` low or with `busy` high changes no lock bit and gives no `wel_clr` pulse.
- R7: A write frame whose chip select rise comes before the first full data byte, or off a byte boundary, changes nothing and gives no `wel_clr` pulse.
- R8: Once a sector's lock-down bit is 1, neither of its bits changes until reset, and reset clears them.
- R9: Each executed write raises `wel_clr` for exactly one cycle, even when lock-down blocks the update. Lock bits never change without that pulse.
- R10: `qry_pe_ok` is combinational from `qry_sector`. It is 0 exactly when that sector's write-lock bit is 1.
- R11: Any other opcode is ignored: `spi_miso` stays 0 and no lock bit changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset (power-up) |
| spi_sck | input | 1 | SPI serial clock, idles low |
| spi_cs_n | input | 1 | SPI chip select, active low |
| spi_mosi | input | 1 | Serial command, address and data in |
| spi_miso | output | 1 | Serial lock byte out |
| busy | input | 1 | Program, erase or write cycle in progress |
| wel | input | 1 | Write enable latch state |
| wel_clr | output | 1 | One-cycle request to clear the write enable latch |
| qry_sector | input | 8 | Sector index to query |
| qry_pe_ok | output | 1 | Program/erase allowed on the queried sector |

## Verification
The checker assumes the following about the inputs:
- Reset is held for at least five clock cycles.
- Each SPI pin stays stable for several system clocks between changes.
- Chip select only moves while SCK is low.
- `wel` is steady from the opcode until the clear pulse.

Under these assumptions the checker requires that a lock-down bit never falls and that a locked-down sector's write-lock bit never moves. It also requires that lock bits change only together with a `wel_clr` pulse, and that `spi_miso` is quiet once chip select has been high for a few cycles. The bench builds every frame from a task that holds each SCK phase for four clocks and raises chip select only with SCK low. It draws random sectors, data, `wel` and `busy` from a seeded generator. It adds directed frames for refused, truncated, multi-byte and unknown-opcode cases.

// File: rtl/slk_pkg.sv
package slk_pkg;
    typedef enum logic [2:0] {
        S_IDLE,
        S_OPCODE,
        S_ADDR,
        S_WDATA,
        S_RDATA,
        S_IGNORE
    } slk_state_e;

    typedef enum logic {
        CMD_READ,
        CMD_WRITE
    } slk_cmd_e;
endpackage

// File: rtl/slk_spi_sync.sv
module slk_spi_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sck_in,
    input  logic cs_n_in,
    input  logic mosi_in,
    output logic sck_rise,
    output logic sck_fall,
    output logic cs_hi,
    output logic mosi_lvl
);
    // one extra stage on SCK for edge detection; all pins share latency
    logic [STAGES:0]   sck_p;
    logic [STAGES-1:0] cs_p;
    logic [STAGES-1:0] mosi_p;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sck_p  <= '0;
            cs_p   <= '1;
            mosi_p <= '0;
        end else begin
            sck_p  <= {sck_p[STAGES-1:0], sck_in};
            cs_p   <= {cs_p[STAGES-2:0], cs_n_in};
            mosi_p <= {mosi_p[STAGES-2:0], mosi_in};
        end
    end

    assign sck_rise = sck_p[STAGES-1] & ~sck_p[STAGES];
    assign sck_fall = ~sck_p[STAGES-1] & sck_p[STAGES];
    assign cs_hi    = cs_p[STAGES-1];
    assign mosi_lvl = mosi_p[STAGES-1];
endmodule

// File: rtl/slk_lock_bank.sv
module slk_lock_bank #(
    parameter int SEC_BITS = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [SEC_BITS-1:0]        wr_sec,
    input  logic [1:0]                 wr_bits,
    input  logic [SEC_BITS-1:0]        rd_sec,
    output logic [7:0]                 rd_byte,
    input  logic [SEC_BITS-1:0]        q_sec,
    output logic                       q_ok,
    output logic [(1<<SEC_BITS)-1:0]   ld_vec,
    output logic [(1<<SEC_BITS)-1:0]   wl_vec
);
    localparam int SECTORS = 1 << SEC_BITS;

    for (genvar g = 0; g < SECTORS; g++) begin : g_sec
        logic ld_q;
        logic wl_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                ld_q <= 1'b0;
                wl_q <= 1'b0;
            end else if (wr_en && (wr_sec == SEC_BITS'(g)) && !ld_q) begin
                ld_q <= wr_bits[1];
                wl_q <= wr_bits[0];
            end
        end
        assign ld_vec[g] = ld_q;
        assign wl_vec[g] = wl_q;
    end

    assign rd_byte = {6'b0, ld_vec[rd_sec], wl_vec[rd_sec]};
    assign q_ok    = ~wl_vec[q_sec];
endmodule

// File: rtl/sector_lock_unit.sv
module sector_lock_unit
    import slk_pkg::*;
#(
    parameter int          SEC_BITS    = 8,
    parameter int          ADDR_BITS   = 24,
    parameter int          SYNC_STAGES = 2,
    parameter logic [7:0]  OP_RD_LOCK  = 8'hE8,
    parameter logic [7:0]  OP_WR_LOCK  = 8'hE5
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                spi_sck,
    input  logic                spi_cs_n,
    input  logic                spi_mosi,
    output logic                spi_miso,
    input  logic                busy,
    input  logic                wel,
    output logic                wel_clr,
    input  logic [SEC_BITS-1:0] qry_sector,
    output logic                qry_pe_ok
);
    localparam int SECTORS = 1 << SEC_BITS;
    localparam int CNT_W   = $clog2(ADDR_BITS + 1);
    localparam logic [CNT_W-1:0] OP_LAST   = CNT_W'(7);
    localparam logic [CNT_W-1:0] ADDR_LAST = CNT_W'(ADDR_BITS - 1);

    logic sck_rise, sck_fall, cs_hi, mosi_lvl;

    slk_spi_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .sck_in   (spi_sck),
        .cs_n_in  (spi_cs_n),
        .mosi_in  (spi_mosi),
        .sck_rise (sck_rise),
        .sck_fall (sck_fall),
        .cs_hi    (cs_hi),
        .mosi_lvl (mosi_lvl)
    );

    slk_state_e             state, nxt;
    slk_cmd_e               cmd;
    logic [6:0]             shreg;
    logic [ADDR_BITS-2:0]   addr_sh;
    logic [CNT_W-1:0]       cnt;
    logic [SEC_BITS-1:0]    sector;
    logic [2:0]             rd_idx;
    logic                   dfull;
    logic                   commit;
    logic [7:0]             opcode;
    logic [ADDR_BITS-1:0]   addr_full;
    logic [7:0]             rd_byte;
    logic [SECTORS-1:0]     ld_vec;
    logic [SECTORS-1:0]     wl_vec;

    assign opcode    = {shreg, mosi_lvl};
    assign addr_full = {addr_sh, mosi_lvl};

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt;
    end

    // next state and write commit
    always_comb begin
        nxt    = state;
        commit = 1'b0;
        if (cs_hi) begin
            nxt    = S_IDLE;
            commit = (state == S_WDATA) && dfull && (cnt[2:0] == 3'd0);
        end else begin
            unique case (state)
                S_IDLE:   nxt = S_OPCODE;
                S_OPCODE: if (sck_rise && cnt == OP_LAST) begin
                    if (opcode == OP_RD_LOCK && !busy)             nxt = S_ADDR;
                    else if (opcode == OP_WR_LOCK && !busy && wel) nxt = S_ADDR;
                    else                                           nxt = S_IGNORE;
                end
                S_ADDR:   if (sck_rise && cnt == ADDR_LAST)
                    nxt = (cmd == CMD_READ) ? S_RDATA : S_WDATA;
                S_WDATA:  nxt = S_WDATA;
                S_RDATA:  nxt = S_RDATA;
                S_IGNORE: nxt = S_IGNORE;
                default:  nxt = S_IDLE;
            endcase
        end
    end

    // outputs and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd      <= CMD_READ;
            shreg    <= '0;
            addr_sh  <= '0;
            cnt      <= '0;
            sector   <= '0;
            rd_idx   <= 3'd7;
            dfull    <= 1'b0;
            spi_miso <= 1'b0;
            wel_clr  <= 1'b0;
        end else begin
            wel_clr <= commit;
            unique case (state)
                S_IDLE: begin
                    cnt      <= '0;
                    dfull    <= 1'b0;
                    rd_idx   <= 3'd7;
                    spi_miso <= 1'b0;
                end
                S_OPCODE: if (sck_rise) begin
                    shreg <= {shreg[5:0], mosi_lvl};
                    if (cnt == OP_LAST) begin
                        cnt <= '0;
                        cmd <= (opcode == OP_RD_LOCK) ? CMD_READ : CMD_WRITE;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                S_ADDR: if (sck_rise) begin
                    addr_sh <= addr_full[ADDR_BITS-2:0];
                    if (cnt == ADDR_LAST) begin
                        cnt    <= '0;
                        sector <= addr_full[ADDR_BITS-1 -: SEC_BITS];
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                S_WDATA: if (sck_rise) begin
                    shreg <= {shreg[5:0], mosi_lvl};
                    cnt   <= {{(CNT_W-3){1'b0}}, cnt[2:0] + 3'd1};
                    if (cnt[2:0] == 3'd7) dfull <= 1'b1;
                end
                S_RDATA: if (sck_fall) begin
                    spi_miso <= rd_byte[rd_idx];
                    rd_idx   <= rd_idx - 3'd1;
                end
                S_IGNORE: spi_miso <= 1'b0;
                default: ;
            endcase
        end
    end

    slk_lock_bank #(.SEC_BITS(SEC_BITS)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (commit),
        .wr_sec  (sector),
        .wr_bits (shreg[1:0]),
        .rd_sec  (sector),
        .rd_byte (rd_byte),
        .q_sec   (qry_sector),
        .q_ok    (qry_pe_ok),
        .ld_vec  (ld_vec),
        .wl_vec  (wl_vec)
    );
endmodule

// File: rtl/slk_chk.sv
module slk_chk #(
    parameter int SECTORS = 256
) (
    input logic               clk,
    input logic               rst_n,
    input logic               spi_cs_n,
    input logic               spi_miso,
    input logic               wel,
    input logic               wel_clr,
    input logic [SECTORS-1:0] ld_vec,
    input logic [SECTORS-1:0] wl_vec
);
    // R8
    ld_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> ((($past(ld_vec)) & ~ld_vec) == '0));

    // R8
    ld_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> ((($past(ld_vec)) & ($past(wl_vec) ^ wl_vec)) == '0));

    // R9
    change_needs_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((ld_vec != $past(ld_vec)) || (wl_vec != $past(wl_vec))) |-> wel_clr);

    // R9
    clr_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wel_clr |=> !wel_clr);

    // R6
    clr_needs_wel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wel_clr |-> $past(wel));

    // R1
    miso_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (spi_cs_n && $past(spi_cs_n) && $past(spi_cs_n, 2) && $past(spi_cs_n, 3)
         && $past(spi_cs_n, 4)) |-> !spi_miso);
endmodule

bind sector_lock_unit slk_chk #(.SECTORS(SECTORS)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .spi_cs_n (spi_cs_n),
    .spi_miso (spi_miso),
    .wel      (wel),
    .wel_clr  (wel_clr),
    .ld_vec   (ld_vec),
    .wl_vec   (wl_vec)
);

// File: tb/test_sector_lock_unit.sv
`timescale 1ns/1ps
module test_sector_lock_unit;
    localparam int HALF = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       spi_sck = 1'b0;
    logic       spi_cs_n = 1'b1;
    logic       spi_mosi = 1'b0;
    logic       spi_miso;
    logic       busy = 1'b0;
    logic       wel = 1'b1;
    logic       wel_clr;
    logic [7:0] qry_sector = 8'd0;
    logic       qry_pe_ok;

    int n_chk = 0;
    int n_fail = 0;
    int clr_cnt = 0;
    logic m_ld [256];
    logic m_wl [256];

    always #2 clk = ~clk;

    sector_lock_unit i_sector_lock_unit (
        .clk(clk), .rst_n(rst_n), .spi_sck(spi_sck), .spi_cs_n(spi_cs_n),
        .spi_mosi(spi_mosi), .spi_miso(spi_miso), .busy(busy), .wel(wel),
        .wel_clr(wel_clr), .qry_sector(qry_sector), .qry_pe_ok(qry_pe_ok)
    );

    always @(negedge clk) if (wel_clr) clr_cnt++;

    function automatic logic [7:0] exp_byte(input int s);
        return {6'b0, m_ld[s], m_wl[s]};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < 256; i++) begin
            m_ld[i] = 1'b0;
            m_wl[i] = 1'b0;
        end
    endtask

    task automatic spi_bit(input logic b, output logic s);
        spi_mosi = b;
        repeat (HALF) @(negedge clk);
        s = spi_miso;
        spi_sck = 1'b1;
        repeat (HALF) @(negedge clk);
        spi_sck = 1'b0;
    endtask

    task automatic spi_byte(input logic [7:0] b, output logic [7:0] r);
        for (int i = 7; i >= 0; i--) spi_bit(b[i], r[i]);
    endtask

    task automatic cs_open();
        @(negedge clk);
        spi_cs_n = 1'b0;
        repeat (HALF) @(negedge clk);
    endtask

    task automatic cs_close();
        repeat (HALF) @(negedge clk);
        spi_cs_n = 1'b1;
        repeat (10) @(negedge clk);
    endtask

    task automatic send_head(input logic [7:0] op, input logic [7:0] sec, output logic [7:0] r);
        logic [15:0] low;
        low = 16'($urandom);
        spi_byte(op, r);
        spi_byte(sec, r);
        spi_byte(low[15:8], r);
        spi_byte(low[7:0], r);
    endtask

    task automatic rd_lock(input logic [7:0] sec, output logic [7:0] b0, output logic [7:0] b1);
        logic [7:0] r;
        cs_open();
        send_head(8'hE8, sec, r);
        spi_byte(8'h00, b0);
        spi_byte(8'h00, b1);
        cs_close();
    endtask

    // sends nbits of data taken MSB first from d
    task automatic wr_lock(input logic [7:0] sec, input logic [15:0] d, input int nbits);
        logic [7:0] r;
        logic s;
        cs_open();
        send_head(8'hE5, sec, r);
        for (int i = 0; i < nbits; i++) spi_bit(d[15-i], s);
        cs_close();
    endtask

    task automatic wr_model(input int sec, input logic [1:0] bits);
        if (!m_ld[sec]) begin
            m_ld[sec] = bits[1];
            m_wl[sec] = bits[0];
        end
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin : main
        logic [7:0] b0, b1, r;
        int c0;
        void'($urandom(32'd2024));
        model_reset();
        repeat (8) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        // R1 reset state
        check("R1 miso", spi_miso, 1'b0);
        check("R1 wel_clr", wel_clr, 1'b0);
        qry_sector = 8'd0;   #1 check("R1 query 0", qry_pe_ok, 1'b1);
        qry_sector = 8'd255; #1 check("R1 query 255", qry_pe_ok, 1'b1);
        rd_lock(8'd0, b0, b1);
        check("R1 R2 read after reset", b0, 8'h00);

        // R5 write 0xFD: reserved bits dropped, bits 1:0 = 01
        c0 = clr_cnt;
        wr_lock(8'd3, 16'hFD00, 8);
        wr_model(3, 2'b01);
        check("R9 clr pulse", clr_cnt - c0, 1);
        rd_lock(8'd3, b0, b1);
        check("R2 R5 read byte", b0, 8'h01);
        check("R3 repeated byte", b1, 8'h01);
        @(negedge clk) qry_sector = 8'd3; #1 check("R10 locked sector", qry_pe_ok, 1'b0);
        qry_sector = 8'd4; #1 check("R10 free sector", qry_pe_ok, 1'b1);

        // R6 wel low, then busy high
        c0 = clr_cnt;
        wel = 1'b0;
        wr_lock(8'd7, 16'h0100, 8);
        wel = 1'b1;
        busy = 1'b1;
        wr_lock(8'd7, 16'h0100, 8);
        busy = 1'b0;
        check("R6 no clr", clr_cnt - c0, 0);
        rd_lock(8'd7, b0, b1);
        check("R6 sector unchanged", b0, 8'h00);

        // R4 busy read of a locked sector
        busy = 1'b1;
        rd_lock(8'd3, b0, b1);
        busy = 1'b0;
        check("R4 refused byte0", b0, 8'h00);
        check("R4 refused byte1", b1, 8'h00);
        rd_lock(8'd3, b0, b1);
        check("R4 state kept", b0, 8'h01);

        // R7 truncated frames
        c0 = clr_cnt;
        wr_lock(8'd9, 16'h0100, 5);
        wr_lock(8'd9, 16'h0100, 0);
        wr_lock(8'd9, 16'h0101, 12);
        check("R7 no clr", clr_cnt - c0, 0);
        rd_lock(8'd9, b0, b1);
        check("R7 sector unchanged", b0, 8'h00);

        // R5 two data bytes: last byte wins
        wr_lock(8'd9, 16'h0201, 16);
        wr_model(9, 2'b01);
        rd_lock(8'd9, b0, b1);
        check("R5 last byte", b0, exp_byte(9));

        // R11 unknown opcode
        c0 = clr_cnt;
        cs_open();
        send_head(8'h9F, 8'd3, r);
        spi_byte(8'h01, b0);
        cs_close();
        check("R11 miso quiet", b0, 8'h00);
        check("R11 no clr", clr_cnt - c0, 0);
        rd_lock(8'd3, b0, b1);
        check("R11 sector kept", b0, 8'h01);

        // R8 R9 lock-down
        wr_lock(8'd20, 16'h0300, 8);
        wr_model(20, 2'b11);
        c0 = clr_cnt;
        wr_lock(8'd20, 16'h0000, 8);
        check("R9 clr even when frozen", clr_cnt - c0, 1);
        rd_lock(8'd20, b0, b1);
        check("R8 frozen", b0, 8'h03);

        // random mix
        for (int it = 0; it < 70; it++) begin
            int kind, sec;
            logic [7:0] d;
            logic w, bz;
            kind = int'($urandom % 4);
            sec  = int'($urandom % 32);
            if (kind < 2) begin
                d  = 8'($urandom);
                d[1] = (($urandom % 6) == 0);
                w  = (($urandom % 5) != 0);
                bz = (($urandom % 6) == 0);
                wel = w;
                busy = bz;
                c0 = clr_cnt;
                wr_lock(8'(sec), {d, 8'h00}, 8);
                wel = 1'b1;
                busy = 1'b0;
                if (w && !bz) wr_model(sec, d[1:0]);
                check("R5 R6 R9 random clr", clr_cnt - c0, (w && !bz) ? 1 : 0);
            end else if (kind == 2) begin
                rd_lock(8'(sec), b0, b1);
                check("R2 random read", b0, exp_byte(sec));
                check("R3 random repeat", b1, exp_byte(sec));
            end else begin
                for (int q = 0; q < 3; q++) begin
                    int s2;
                    s2 = int'($urandom % 32);
                    @(negedge clk) qry_sector = 8'(s2);
                    #1 check("R10 random query", qry_pe_ok, !m_wl[s2]);
                end
            end
        end

        // R8 R1 reset clears lock-down
        @(negedge clk) rst_n = 1'b0;
        repeat (6) @(negedge clk);
        rst_n = 1'b1;
        model_reset();
        repeat (4) @(negedge clk);
        rd_lock(8'd20, b0, b1);
        check("R8 reset clears", b0, 8'h00);
        wr_lock(8'd20, 16'h0100, 8);
        wr_model(20, 2'b01);
        rd_lock(8'd20, b0, b1);
        check("R8 writable after reset", b0, 8'h01);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule